// File: doc/BRIEF.md
# Eight-Lane Q15 Fraction Multiplier with Accumulators

This block multiplies two vectors of eight signed 16-bit Q15 fractions lane by lane. Each lane owns a 48-bit signed accumulator. A 4-bit routing code decides which element of the second vector reaches each lane. The second vector can be used element by element, repeated in pairs, repeated in groups of four, or reduced to one element that is broadcast to every lane.

When `start` is high, every lane forms the signed product and doubles it. The `acc_mode` input then picks one of two paths:

- Fraction mode: the lane adds a half-LSB rounding constant of 0x8000 and overwrites its accumulator with the sum.
- Accumulate mode: the lane adds the doubled product to its accumulator, with no rounding, and the sum wraps modulo 2^48.

Each lane's 16-bit result is taken from accumulator bits 31..16. Saturation is applied only on this result path. The new accumulators, the saturated results and a one-cycle `done` pulse all appear one clock after `start`. Without `start`, the accumulators and results hold their values.

Top module: `frac_vmul`

## Requirements
- R1: After reset, every accumulator and every result lane is zero and `done` is low.
- R2: When `start` is high with `acc_mode`=0, lane i's accumulator becomes (2·a_i·b_sel(i) + 0x8000) as a 48-bit two's-complement value. The previous accumulator value is discarded.
- R3: When `start` is high with `acc_mode`=1, lane i's accumulator becomes (acc_i + 2·a_i·b_sel(i)) mod 2^48, with no rounding term.
- R4: If accumulator bits 47..31 are all equal, result lane i equals accumulator bits 31..16.
- R5: If the accumulator is negative (bit 47 = 1) and below -2^31, result lane i is 0x8000.
- R6: If the accumulator is non-negative and above 2^31-1, result lane i is 0x7FFF. For example, 0x8000·0x8000 in fraction mode gives accumulator 0x0000_8000_8000 and result 0x7FFF.
- R7: Routing codes 0 and 1 give lane i element i of `src_b`.
- R8: Routing codes 2 and 3 give lane i the element (i with bit 0 cleared) + code[0].
- R9: Routing codes 4 to 7 give lane i the element (i with bits 1..0 cleared) + code[1:0].
- R10: Routing codes 8 to 15 give every lane the element code[2:0].
- R11: The accumulators, the results and a single-cycle `done` appear on the clock edge after the one that samples `start`. Without `start`, the accumulators and results do not change and `done` is low.

Lane i occupies bits [16i+15:16i] of `src_a`, `src_b` and `result`, and bits [48i+47:48i] of `acc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts one operation on all lanes |
| acc_mode | input | 1 | 0 = fraction with rounding and overwrite, 1 = accumulate |
| route_code | input | 4 | Routing code that selects `src_b` elements for each lane |
| src_a | input | 128 | First operand vector, eight Q15 elements |
| src_b | input | 128 | Second operand vector, eight Q15 elements |
| result | output | 128 | Saturated 16-bit results, one per lane |
| acc_out | output | 384 | The eight 48-bit accumulators |
| done | output | 1 | High for one cycle when new values are visible |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples `start`. The bench raises `start` on a falling edge and drops it on the next falling edge. On that second falling edge it compares `done`, all eight accumulators and all eight result lanes against its own arithmetic model. One falling edge later, `start` is still low, and the bench checks that `done` has dropped and that every accumulator and result has held its value.

// File: rtl/frac_vmul_pkg.sv
package frac_vmul_pkg;

   typedef enum logic [1:0] {
      RT_LANEWISE = 2'd0,
      RT_PAIRS    = 2'd1,
      RT_QUADS    = 2'd2,
      RT_SPLAT    = 2'd3
   } route_class_e;

   // Decode priority runs from the top bit of the code downward.
   function automatic route_class_e route_class(input logic [3:0] code);
      if (code[3])      return RT_SPLAT;
      else if (code[2]) return RT_QUADS;
      else if (code[1]) return RT_PAIRS;
      else              return RT_LANEWISE;
   endfunction

endpackage

// File: rtl/fvm_operand_route.sv
module fvm_operand_route
   import frac_vmul_pkg::*;
#(
   parameter int LANES = 8,
   parameter int EW    = 16,
   parameter int CW    = 4
) (
   input  logic [CW-1:0]       code,
   input  logic [LANES*EW-1:0] vec_in,
   output logic [LANES*EW-1:0] vec_out
);
   localparam int IW = $clog2(LANES);

   if (LANES != 8) begin : g_lane_chk
      $error("fvm_operand_route: LANES must be 8");
   end
   if (CW != IW + 1) begin : g_code_chk
      $error("fvm_operand_route: CW must be clog2(LANES)+1");
   end

   route_class_e cls;
   assign cls = route_class(code);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int PAIR_BASE = i & ~1;
      localparam int QUAD_BASE = i & ~3;
      logic [IW-1:0] idx;

      always_comb begin
         unique case (cls)
            RT_PAIRS: idx = IW'(PAIR_BASE) + IW'(code[0]);
            RT_QUADS: idx = IW'(QUAD_BASE) + IW'(code[1:0]);
            RT_SPLAT: idx = code[IW-1:0];
            default:  idx = IW'(i);
         endcase
      end

      assign vec_out[i*EW +: EW] = vec_in[idx*EW +: EW];
   end

endmodule

// File: rtl/fvm_clamp.sv
module fvm_clamp #(
   parameter int EW = 16,
   parameter int AW = 48
) (
   input  logic [AW-1:0] acc,
   output logic [EW-1:0] sat
);
   localparam int TOP = 2*EW - 1;
   localparam logic [EW-1:0] POS_LIM = {1'b0, {(EW-1){1'b1}}};
   localparam logic [EW-1:0] NEG_LIM = {1'b1, {(EW-1){1'b0}}};

   if (AW <= 2*EW) begin : g_width_chk
      $error("fvm_clamp: AW must exceed 2*EW");
   end

   logic [AW-1-TOP:0] upper;
   logic              in_range;

   assign upper    = acc[AW-1:TOP];
   assign in_range = (&upper) | ~(|upper);

   always_comb begin
      if (in_range)         sat = acc[TOP:EW];
      else if (acc[AW-1])   sat = NEG_LIM;
      else                  sat = POS_LIM;
   end

endmodule

// File: rtl/fvm_lane.sv
module fvm_lane #(
   parameter int EW = 16,
   parameter int AW = 48
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          acc_mode,
   input  logic [EW-1:0] op_a,
   input  logic [EW-1:0] op_b,
   output logic [AW-1:0] acc_q,
   output logic [EW-1:0] res_q
);
   localparam int PW = 2*EW;
   localparam logic [AW-1:0] ROUND_K = {{(AW-EW){1'b0}}, 1'b1, {(EW-1){1'b0}}};
   localparam logic [EW-1:0] POS_LIM = {1'b0, {(EW-1){1'b1}}};
   localparam logic [EW-1:0] NEG_LIM = {1'b1, {(EW-1){1'b0}}};

   if (AW < PW + 2) begin : g_width_chk
      $error("fvm_lane: AW must be at least 2*EW+2");
   end

   logic signed [PW-1:0] prod;
   logic [AW-1:0]        prod_ext;
   logic [AW-1:0]        prod_dbl;
   logic [AW-1:0]        acc_d;
   logic [EW-1:0]        sat_d;

   assign prod     = $signed(op_a) * $signed(op_b);
   assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
   assign prod_dbl = {prod_ext[AW-2:0], 1'b0};
   assign acc_d    = acc_mode ? (acc_q + prod_dbl) : (prod_dbl + ROUND_K);

   fvm_clamp #(.EW(EW), .AW(AW)) u_clamp (
      .acc (acc_d),
      .sat (sat_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         res_q <= '0;
      end else if (start) begin
         acc_q <= acc_d;
         res_q <= sat_d;
      end
   end

   AST_FRAC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !acc_mode) |=> (acc_q[0] == 1'b0)); // R2
   AST_MAC_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && acc_mode) |=> (acc_q[0] == $past(acc_q[0]))); // R3
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(acc_q) && $stable(res_q))); // R11
   AST_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      ((&acc_q[AW-1:PW-1]) || !(|acc_q[AW-1:PW-1])) |-> (res_q == acc_q[PW-1:EW])); // R4
   AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_q[AW-1] && !(&acc_q[AW-1:PW-1])) |-> (res_q == NEG_LIM)); // R5
   AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_q[AW-1] && (|acc_q[AW-1:PW-1])) |-> (res_q == POS_LIM)); // R6

endmodule

// File: rtl/frac_vmul.sv
module frac_vmul #(
   parameter int LANES = 8,
   parameter int EW    = 16,
   parameter int AW    = 48,
   parameter int CW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                acc_mode,
   input  logic [CW-1:0]       route_code,
   input  logic [LANES*EW-1:0] src_a,
   input  logic [LANES*EW-1:0] src_b,
   output logic [LANES*EW-1:0] result,
   output logic [LANES*AW-1:0] acc_out,
   output logic                done
);
   logic [LANES*EW-1:0] b_routed;

   fvm_operand_route #(.LANES(LANES), .EW(EW), .CW(CW)) u_route (
      .code    (route_code),
      .vec_in  (src_b),
      .vec_out (b_routed)
   );

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      fvm_lane #(.EW(EW), .AW(AW)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (start),
         .acc_mode (acc_mode),
         .op_a     (src_a[i*EW +: EW]),
         .op_b     (b_routed[i*EW +: EW]),
         .acc_q    (acc_out[i*AW +: AW]),
         .res_q    (result[i*EW +: EW])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done <= 1'b0;
      else        done <= start;
   end

   AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done); // R11
   AST_SPLAT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      route_code[CW-1] |-> (b_routed[EW-1:0] == b_routed[(LANES-1)*EW +: EW])); // R10

endmodule

// File: tb/frac_vmul_test.sv
module frac_vmul_test;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         acc_mode = 1'b0;
   logic [3:0]   route_code = '0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic [127:0] result;
   logic [383:0] acc_out;
   logic         done;

   int checks = 0;
   int errors = 0;
   logic [47:0] m_acc [8];
   logic [15:0] m_res [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_vmul uut (
      .clk(clk), .rst_n(rst_n), .start(start), .acc_mode(acc_mode),
      .route_code(route_code), .src_a(src_a), .src_b(src_b),
      .result(result), .acc_out(acc_out), .done(done)
   );

   task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string route_tag(input logic [3:0] c);
      if (c[3])      return "R10";
      else if (c[2]) return "R9";
      else if (c[1]) return "R8";
      else           return "R7";
   endfunction

   function automatic int src_idx(input int lane, input logic [3:0] c);
      if (c[3])      return int'(c[2:0]);
      else if (c[2]) return (lane & ~3) + int'(c[1:0]);
      else if (c[1]) return (lane & ~1) + int'(c[0]);
      else           return lane;
   endfunction

   function automatic logic [15:0] sat_model(input logic [47:0] a);
      longint s = longint'($signed(a));
      if (s > 64'sd2147483647)       return 16'h7FFF;
      else if (s < -64'sd2147483648) return 16'h8000;
      else                            return a[31:16];
   endfunction

   function automatic string res_tag(input logic [47:0] a);
      longint s = longint'($signed(a));
      if (s > 64'sd2147483647)       return "R6";
      else if (s < -64'sd2147483648) return "R5";
      else                            return "R4";
   endfunction

   task automatic do_op(input logic [127:0] a, input logic [127:0] b,
                        input logic [3:0] c, input logic mode);
      for (int l = 0; l < 8; l++) begin
         logic [15:0] av = a[l*16 +: 16];
         logic [15:0] bv = b[src_idx(l, c)*16 +: 16];
         longint p = longint'($signed(av)) * longint'($signed(bv));
         longint d = p * 2;
         m_acc[l] = mode ? (m_acc[l] + d[47:0]) : (d[47:0] + 48'h8000);
         m_res[l] = sat_model(m_acc[l]);
      end
      @(negedge clk);
      src_a = a; src_b = b; route_code = c; acc_mode = mode; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R11 done", {47'd0, done}, 48'd1);
      for (int l = 0; l < 8; l++) begin
         chk({mode ? "R3 " : "R2 ", route_tag(c), " acc"}, acc_out[l*48 +: 48], m_acc[l]);
         chk({res_tag(m_acc[l]), " ", route_tag(c), " result"},
             {32'd0, result[l*16 +: 16]}, {32'd0, m_res[l]});
      end
      src_a = ~a; src_b = ~b; acc_mode = ~mode;
      @(negedge clk);
      chk("R11 done low", {47'd0, done}, 48'd0);
      for (int l = 0; l < 8; l++) begin
         chk("R11 acc hold", acc_out[l*48 +: 48], m_acc[l]);
         chk("R11 result hold", {32'd0, result[l*16 +: 16]}, {32'd0, m_res[l]});
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int l = 0; l < 8; l++) begin m_acc[l] = '0; m_res[l] = '0; end
      repeat (3) @(negedge clk);
      chk("R1 done", {47'd0, done}, 48'd0);
      chk("R1 acc", acc_out[47:0] | acc_out[383:336], 48'd0);
      chk("R1 result", {32'd0, result[15:0] | result[127:112]}, 48'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 acc after release", {47'd0, |acc_out}, 48'd0);

      // Worst-case fraction product in every lane
      do_op({8{16'h8000}}, {8{16'h8000}}, 4'd0, 1'b0);
      chk("R6 full-scale acc", acc_out[47:0], 48'h0000_8000_8000);
      chk("R6 full-scale result", {32'd0, result[15:0]}, 48'h7FFF);

      // Negative run-away through accumulation
      do_op({8{16'h8000}}, {8{16'h7FFF}}, 4'd0, 1'b0);
      for (int k = 0; k < 3; k++) do_op({8{16'h8000}}, {8{16'h7FFF}}, 4'd9, 1'b1);
      chk("R5 negative saturation", {32'd0, result[31:16]}, 48'h8000);

      // Positive run-away through accumulation
      do_op({8{16'h7FFF}}, {8{16'h7FFF}}, 4'd4, 1'b0);
      for (int k = 0; k < 3; k++) do_op({8{16'h7FFF}}, {8{16'h7FFF}}, 4'd2, 1'b1);
      chk("R6 positive saturation", {32'd0, result[127:112]}, 48'h7FFF);

      // Distinct lane values to expose routing
      do_op({16'h0800, 16'h0700, 16'h0600, 16'h0500, 16'h0400, 16'h0300, 16'h0200, 16'h0100},
            {16'h4000, 16'h3800, 16'h3000, 16'h2800, 16'h2000, 16'h1800, 16'h1000, 16'h0800},
            4'd13, 1'b0);

      // Sweep every routing code in both modes
      for (int c = 0; c < 16; c++) begin
         for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 3; v++) begin
               do_op({$urandom, $urandom, $urandom, $urandom},
                     {$urandom, $urandom, $urandom, $urandom},
                     4'(c), 1'(m));
            end
         end
      end
      summary();
   end

endmodule